// File: doc/BRIEF.md
# Cut-Spaced Multiply-Add FIR Filter

This block is a fixed-point finite impulse response filter made of a row of multiply-add sections. Input samples travel down a delay line from section 0 toward section TAPS-1. The partial sum is seeded with zero at section 0 and runs alongside the samples in the same direction, so section i adds the product of its coefficient and its sample to the sum it receives from section i-1. The last section's sum becomes the filter output.

The row is split into groups of CUT_EVERY sections. A register on the sum path closes each group, and the last one of these registers drives the output. At every internal group boundary the sample delay line carries one extra register. This keeps each sample aligned with the sum it joins, so the result is the exact convolution, delayed by one clock edge per group. A small CUT_EVERY gives a short combinational path and costs more registers. A large CUT_EVERY gives a longer path and fewer registers. The coefficients are a static parameter vector, with tap 0 in the least significant DW bits. Samples are accepted on every clock edge. When the valid strobe is low, the sample that enters the delay line is zero.

Top module: `flexcut_fir`

## Requirements
- R1: With G = TAPS/CUT_EVERY groups, the output after the clock edge that accepts sample n (counting that edge as the first of G) equals the sum over k = 0..TAPS-1 of h[k]·x[n-k]. Here h[k] is bits [k·DW +: DW] of COEFS, read as a signed value.
- R2: out_valid is in_valid delayed by the same G edges. out_valid is high exactly when the sample accepted G-1 edges earlier had in_valid high.
- R3: A sample presented while in_valid is low enters the filter as zero. Its data bits have no effect on out_sum.
- R4: A synchronous active-high reset clears every delay-line, sum and valid register. On the edge after reset is released, out_sum is 0 and out_valid is 0.
- R5: Arithmetic is signed and carries full precision. out_sum is 2·DW + clog2(TAPS) bits wide and does not overflow, even when every sample and every coefficient is -2^(DW-1).
- R6: A single sample of value 1 surrounded by zeros produces h[0], h[1], …, h[TAPS-1] on consecutive cycles, starting G edges after it is accepted.
- R7: Changing CUT_EVERY (which must divide TAPS) changes only the latency G. It does not change the output sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when in_sample carries a real sample |
| in_sample | input | DW | Signed input sample |
| out_valid | output | 1 | Valid strobe aligned with out_sum |
| out_sum | output | 2·DW+clog2(TAPS) | Signed full-precision filter output |

## Verification
The bench drives one stimulus stream into four instances: cut spacings of 1, 2 and 4 sections with mixed coefficients including both extreme values, plus one instance whose coefficients are all the most negative value. Each instance is compared with a convolution computed in the bench, on every cycle.

The stimulus is built to expose specific faults:
- An impulse exposes a misplaced boundary register: it produces a coefficient sequence that is out of order or shifted by a cycle.
- Stretches with in_valid low and random data bits catch an ungated sample, which leaks garbage into the sum.
- Runs at -128 and +127 catch a sum that is too narrow, which wraps sign.
- A reset in mid-stream catches a sum or skew register that is left uncleared, which would carry stale energy past the reset.

// File: rtl/cfir_pkg.sv
package cfir_pkg;

    // Width of a full-precision sum of taps products of two dw-bit signed words
    function automatic int acc_width(input int dw, input int taps);
        return 2 * dw + $clog2(taps);
    endfunction

endpackage

// File: rtl/cfir_section.sv
module cfir_section #(
    parameter int DW = 16,
    parameter int AW = 35,
    parameter logic signed [DW-1:0] COEF = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] sample,
    input  logic signed [AW-1:0] sum_in,
    output logic signed [AW-1:0] sum_out
);

    localparam int PW = 2 * DW;

    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_ext;

    always_comb begin
        prod     = sample * COEF;
        prod_ext = AW'(prod);
        sum_out  = sum_in + prod_ext;
    end

    // A zero sample must leave the partial sum untouched (gating of R3)
    assert_zero_sample_passthru_R3: assert property (
        @(posedge clk) disable iff (rst)
        (sample == '0) |-> (sum_out == sum_in)
    );

endmodule

// File: rtl/cfir_sample_link.sv
module cfir_sample_link #(
    parameter int DW    = 16,
    parameter bit EXTRA = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] d,
    output logic signed [DW-1:0] q
);

    if (EXTRA) begin : g_boundary
        logic signed [DW-1:0] stage_a;
        logic signed [DW-1:0] stage_b;
        logic [1:0]           settle;

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_a <= '0;
                stage_b <= '0;
                settle  <= '0;
            end else begin
                stage_a <= d;
                stage_b <= stage_a;
                if (settle != 2'd2) settle <= settle + 2'd1;
            end
        end
        assign q = stage_b;

        // Boundary links add one cycle of skew for the sum register (R1)
        assert_boundary_skew_R1: assert property (
            @(posedge clk) disable iff (rst)
            (settle == 2'd2) |-> (q == $past(d, 2))
        );
    end else begin : g_plain
        logic signed [DW-1:0] stage_a;

        always_ff @(posedge clk) begin
            if (rst) stage_a <= '0;
            else     stage_a <= d;
        end
        assign q = stage_a;
    end

endmodule

// File: rtl/cfir_valid_pipe.sv
module cfir_valid_pipe #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic vin,
    output logic vout
);

    logic [DEPTH-1:0] shift_q;

    if (DEPTH == 1) begin : g_single
        always_ff @(posedge clk) begin
            if (rst) shift_q <= '0;
            else     shift_q <= vin;
        end
    end else begin : g_multi
        always_ff @(posedge clk) begin
            if (rst) shift_q <= '0;
            else     shift_q <= {shift_q[DEPTH-2:0], vin};
        end
    end

    assign vout = shift_q[DEPTH-1];

endmodule

// File: rtl/flexcut_fir.sv
module flexcut_fir #(
    parameter int TAPS      = 8,
    parameter int CUT_EVERY = 2,
    parameter int DW        = 16,
    parameter logic [TAPS*DW-1:0] COEFS =
        128'h0040_FFC0_0200_7FFF_8000_0200_FFC0_0040
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic                                        in_valid,
    input  logic signed [DW-1:0]                        in_sample,
    output logic                                        out_valid,
    output logic signed [cfir_pkg::acc_width(DW,TAPS)-1:0] out_sum
);

    localparam int AW     = cfir_pkg::acc_width(DW, TAPS);
    localparam int GROUPS = TAPS / CUT_EVERY;
    localparam int FLUSH  = TAPS + GROUPS;
    localparam int CW     = $clog2(FLUSH + 1) + 1;

    initial begin
        if (TAPS % CUT_EVERY != 0)
            $error("CUT_EVERY must divide TAPS");
    end

    logic signed [DW-1:0] smp   [TAPS];
    logic signed [AW-1:0] s_in  [TAPS];
    logic signed [AW-1:0] s_out [TAPS];
    logic signed [AW-1:0] cut_q [GROUPS];

    // Invalid samples enter as zero
    assign smp[0] = in_valid ? in_sample : '0;

    for (genvar i = 0; i < TAPS; i++) begin : g_sec
        if (i > 0) begin : g_link
            cfir_sample_link #(
                .DW    (DW),
                .EXTRA ((i % CUT_EVERY) == 0)
            ) u_link (
                .clk (clk),
                .rst (rst),
                .d   (smp[i-1]),
                .q   (smp[i])
            );
        end

        if (i == 0) begin : g_seed
            assign s_in[i] = '0;
        end else if ((i % CUT_EVERY) == 0) begin : g_from_cut
            assign s_in[i] = cut_q[(i / CUT_EVERY) - 1];
        end else begin : g_chain
            assign s_in[i] = s_out[i-1];
        end

        cfir_section #(
            .DW   (DW),
            .AW   (AW),
            .COEF (COEFS[i*DW +: DW])
        ) u_sec (
            .clk     (clk),
            .rst     (rst),
            .sample  (smp[i]),
            .sum_in  (s_in[i]),
            .sum_out (s_out[i])
        );
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_cut
        logic signed [AW-1:0] held;
        always_ff @(posedge clk) begin
            if (rst) held <= '0;
            else     held <= s_out[(g + 1) * CUT_EVERY - 1];
        end
        assign cut_q[g] = held;
    end

    assign out_sum = cut_q[GROUPS-1];

    cfir_valid_pipe #(
        .DEPTH (GROUPS)
    ) u_vpipe (
        .clk  (clk),
        .rst  (rst),
        .vin  (in_valid),
        .vout (out_valid)
    );

    // Checker state: consecutive idle inputs and edges since last valid
    logic [CW-1:0] idle_run;
    logic [CW-1:0] since_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_run    <= '0;
            since_valid <= CW'(GROUPS);
        end else begin
            if (in_valid)                   idle_run <= '0;
            else if (idle_run < CW'(FLUSH)) idle_run <= idle_run + 1'b1;
            if (in_valid)                       since_valid <= '0;
            else if (since_valid < CW'(GROUPS)) since_valid <= since_valid + 1'b1;
        end
    end

    assert_reset_clear_R4: assert property (
        @(posedge clk) disable iff (rst)
        $past(rst) |-> (out_sum == '0 && !out_valid)
    );

    assert_idle_flush_R3: assert property (
        @(posedge clk) disable iff (rst)
        (idle_run == CW'(FLUSH)) |-> (out_sum == '0)
    );

    assert_no_stray_valid_R2: assert property (
        @(posedge clk) disable iff (rst)
        (since_valid == CW'(GROUPS)) |-> !out_valid
    );

    assert_valid_arrives_R2: assert property (
        @(posedge clk) disable iff (rst)
        (since_valid == CW'(GROUPS - 1)) |-> out_valid
    );

endmodule

// File: tb/flexcut_fir_bench.sv
module flexcut_fir_bench;

    localparam int TAPS = 8;
    localparam int DW   = 8;
    localparam int AW   = 2 * DW + 3;
    localparam logic [TAPS*DW-1:0] MIXED = 64'h28FF057F800CF903;
    localparam logic [TAPS*DW-1:0] FLOOR = 64'h8080808080808080;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_sample = '0;

    logic v1, v2, v4, vf;
    logic signed [AW-1:0] y1, y2, y4, yf;

    always #5 clk = ~clk;

    flexcut_fir #(.TAPS(TAPS), .CUT_EVERY(2), .DW(DW), .COEFS(MIXED)) u_flexcut_fir (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(v2), .out_sum(y2));
    flexcut_fir #(.TAPS(TAPS), .CUT_EVERY(1), .DW(DW), .COEFS(MIXED)) u_flexcut_fir_k1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(v1), .out_sum(y1));
    flexcut_fir #(.TAPS(TAPS), .CUT_EVERY(4), .DW(DW), .COEFS(MIXED)) u_flexcut_fir_k4 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(v4), .out_sum(y4));
    flexcut_fir #(.TAPS(TAPS), .CUT_EVERY(2), .DW(DW), .COEFS(FLOOR)) u_flexcut_fir_fl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(vf), .out_sum(yf));

    int hmix [TAPS] = '{3, -7, 12, -128, 127, 5, -1, 40};
    int hist [0:2047];
    bit vh   [0:2047];
    int cyc  = 0;
    int base = 0;
    int checks = 0;
    int fails  = 0;
    string req = "R4";

    function automatic longint model_y(input bit floor_set, input int g);
        longint acc = 0;
        for (int j = 0; j < TAPS; j++) begin
            int idx = cyc - g - j;
            if (idx >= base) acc += longint'(floor_set ? -128 : hmix[j]) * hist[idx];
        end
        return acc;
    endfunction

    function automatic bit model_v(input int g);
        int idx = cyc - g;
        return (idx >= base) ? vh[idx] : 1'b0;
    endfunction

    task automatic chk(input string nm, input logic v, input logic signed [AW-1:0] y,
                       input int g, input bit floor_set);
        longint ey = model_y(floor_set, g);
        bit ev = model_v(g);
        checks++;
        if (longint'(y) != ey || v !== ev) begin
            fails++;
            $display("FAIL %s %s cyc=%0d actual sum=%0d valid=%0b expected sum=%0d valid=%0b",
                     req, nm, cyc, y, v, ey, ev);
        end
    endtask

    // One cycle: check outputs from the previous edge, then present new input
    task automatic step(input logic v, input logic signed [DW-1:0] d);
        @(negedge clk);
        chk("k1", v1, y1, 8, 1'b0);
        chk("k2", v2, y2, 4, 1'b0);
        chk("k4", v4, y4, 2, 1'b0);
        chk("floor", vf, yf, 4, 1'b1);
        in_valid  = v;
        in_sample = d;
        hist[cyc] = v ? int'(d) : 0;
        vh[cyc]   = v;
        cyc++;
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_sample = DW'($urandom);
        end
        @(negedge clk);
        rst      = 1'b0;
        in_valid = 1'b0;
        base     = cyc;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R4: reset state visible on first cycles after release
        req = "R4";
        do_reset(3);
        for (int i = 0; i < 3; i++) step(1'b0, 8'sh5A);

        // R6: impulse response walks the coefficients in tap order
        req = "R6";
        step(1'b1, 8'sd1);
        for (int i = 0; i < 14; i++) step(1'b1, 8'sd0);

        // R1 and R7: continuous random samples, all cut spacings compared
        req = "R1_R7";
        for (int i = 0; i < 300; i++) step(1'b1, DW'($urandom));

        // R3 and R2: random gaps with junk data on idle cycles
        req = "R3_R2";
        for (int i = 0; i < 300; i++) step(1'($urandom), DW'($urandom));
        for (int i = 0; i < 20; i++) step(1'b0, DW'($urandom));

        // R5: extreme magnitudes
        req = "R5";
        for (int i = 0; i < 20; i++) step(1'b1, -8'sd128);
        for (int i = 0; i < 20; i++) step(1'b1, 8'sd127);
        for (int i = 0; i < 20; i++) step(1'b1, (i % 2) ? 8'sd127 : -8'sd128);

        // R4: reset in mid-stream discards all history
        req = "R4";
        do_reset(2);
        for (int i = 0; i < 4; i++) step(1'b0, DW'($urandom));
        req = "R1";
        for (int i = 0; i < 40; i++) step(1'b1, DW'($urandom));
        step(1'b0, 8'sd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule